// File: doc/BRIEF.md
# ATM F5 OAM Defect Supervisor

This block watches a small set of ATM virtual channel connections for three fault types: alarm indication signal (AIS), remote defect indication (RDI) and loss of continuity (LOC). Cell events from an upstream OAM cell classifier arrive at any time. They are kept in per-connection pending flags until a periodic scan reaches that connection. At each visit the scan consumes the pending flags and steps three independent normal/defect/failure state machines for that connection. It latches sticky transition indications and, when needed, pulses a request for an AIS cell in the forward direction and an RDI cell in the backward direction.

A controller reads a 16-bit status word for any connection through a one-cycle read port, and the read clears that connection's transition indications. A line-level PHY error flag makes every visited connection issue both insertion requests with no software involvement. Connection count and all tick limits are parameters.

Top module: `oam_f5_supervisor`

## Requirements
- R1: After reset every connection is in the normal state for all three faults, no transition indication is set, no request is raised and `rd_vld` is 0.
- R2: For AIS and RDI, a visit that sees a pending cell moves a normal machine to defect. A defect machine enters failure on the FAIL_TICKS-th later visit. From defect or failure, CLEAR_TICKS consecutive visits with no pending cell return it to normal. When the clear limit and the failure limit are reached on the same visit, the return to normal wins.
- R3: The LOC defect condition holds at a visit when LOC_TICKS consecutive visits (this one included) saw no pending user or continuity-check cell. This condition drives a third machine with the same state rules as R2.
- R4: Status word fields: bit0 AIS defect, bit1 AIS failure, bit2 RDI defect, bit3 RDI failure, bit4 LOC defect, bit5 LOC failure, bit8 AIS defect-to-failure, bit9 AIS failure-to-normal, bit10 RDI defect-to-failure, bit11 RDI failure-to-normal. Bits 6, 7 and 12 to 15 always read 0. The defect bit is set only in the defect state and the failure bit only in the failure state.
- R5: The four transition indications are sticky. Each is set by its AIS or RDI transition (defect to failure, failure to normal) and stays set until a read of that connection.
- R6: A read with `rd_en` returns the connection's status from before that cycle's update, one cycle later with `rd_vld`=1. The read clears its indications, but an indication set by a visit in the same cycle survives.
- R7: A visit during which `phy_err` is 1 gives, in the next cycle, a one-cycle `fwd_ais_req` pulse with `fwd_ais_conn` equal to the visited index. No forward request occurs otherwise.
- R8: A visit gives, in the next cycle, a one-cycle `bwd_rdi_req` with the visited index when `phy_err` is 1 or when that connection's AIS or LOC machine is in failure after the visit.
- R9: Each cycle with `scan_en`=1 visits the connection at the scan index, then advances the index by one, wrapping from N_CONN-1 to 0. Without `scan_en`, no state changes except by reads and pending flags.
- R10: A cell event sets its pending flag, and the flag stays set until the connection's next visit consumes it. An event for the connection being visited in the same cycle is kept for the following visit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Visit the connection at the scan index this cycle |
| ais_cell_vld | input | 1 | AIS cell received |
| ais_cell_conn | input | IDX_W | Connection of the AIS cell |
| rdi_cell_vld | input | 1 | RDI cell received |
| rdi_cell_conn | input | IDX_W | Connection of the RDI cell |
| cc_cell_vld | input | 1 | User or continuity-check cell received |
| cc_cell_conn | input | IDX_W | Connection of that cell |
| phy_err | input | 1 | Physical layer error flag |
| rd_en | input | 1 | Status read strobe |
| rd_conn | input | IDX_W | Connection to read |
| rd_vld | output | 1 | Status word valid |
| rd_data | output | 16 | Status word |
| fwd_ais_req | output | 1 | Forward AIS insertion request pulse |
| fwd_ais_conn | output | IDX_W | Connection for the forward request |
| bwd_rdi_req | output | 1 | Backward RDI insertion request pulse |
| bwd_rdi_conn | output | IDX_W | Connection for the backward request |

## Verification
The bench targets events that land on the connection being visited in the same cycle. A design that consumed such an event at once would enter defect a full scan round early. It also reads a connection in the very cycle its machine reaches failure: a design that let the read clear win would lose the defect-to-failure indication, and one that returned post-update state would show failure a cycle too soon. LOC is driven by connections that never see a continuity cell, which exposes off-by-one window counting, and phases of line error check that both requests carry the visited index and stop when the flag drops.

// File: rtl/oam_sup_pkg.sv
package oam_sup_pkg;

    typedef enum logic [1:0] {
        FS_NORM = 2'd0,
        FS_DEF  = 2'd1,
        FS_FAIL = 2'd2
    } fstate_e;

    // fault slots, also the order of state pairs in the status word
    localparam int N_FLT = 3;
    localparam int F_AIS = 0;
    localparam int F_RDI = 1;
    localparam int F_LOC = 2;

    localparam int STAT_W  = 16;
    localparam int IND_W   = 4;
    localparam int IND_LSB = 8;

endpackage

// File: rtl/oam_flt_step.sv
module oam_flt_step
    import oam_sup_pkg::*;
#(
    parameter int FAIL_TICKS  = 3,
    parameter int CLEAR_TICKS = 4,
    parameter int CNT_W       = 3
) (
    input  fstate_e          cur_st,
    input  logic [CNT_W-1:0] cur_pc,
    input  logic [CNT_W-1:0] cur_qc,
    input  logic             hit,
    output fstate_e          nxt_st,
    output logic [CNT_W-1:0] nxt_pc,
    output logic [CNT_W-1:0] nxt_qc,
    output logic             to_fail,
    output logic             to_norm
);

    localparam logic [CNT_W:0] FAIL_LIM = (CNT_W+1)'(FAIL_TICKS);
    localparam logic [CNT_W:0] CLR_LIM  = (CNT_W+1)'(CLEAR_TICKS);

    logic [CNT_W:0] quiet_d;
    logic [CNT_W:0] persist_d;

    always_comb begin
        nxt_st    = cur_st;
        nxt_pc    = cur_pc;
        nxt_qc    = cur_qc;
        to_fail   = 1'b0;
        to_norm   = 1'b0;
        quiet_d   = hit ? '0 : ({1'b0, cur_qc} + 1'b1);
        persist_d = {1'b0, cur_pc} + 1'b1;
        unique case (cur_st)
            FS_NORM: begin
                nxt_pc = '0;
                nxt_qc = '0;
                if (hit) nxt_st = FS_DEF;
            end
            FS_DEF: begin
                if (quiet_d >= CLR_LIM) begin
                    nxt_st = FS_NORM;
                    nxt_pc = '0;
                    nxt_qc = '0;
                end else if (persist_d >= FAIL_LIM) begin
                    nxt_st  = FS_FAIL;
                    nxt_pc  = '0;
                    nxt_qc  = '0;
                    to_fail = 1'b1;
                end else begin
                    nxt_pc = persist_d[CNT_W-1:0];
                    nxt_qc = quiet_d[CNT_W-1:0];
                end
            end
            FS_FAIL: begin
                if (quiet_d >= CLR_LIM) begin
                    nxt_st  = FS_NORM;
                    nxt_pc  = '0;
                    nxt_qc  = '0;
                    to_norm = 1'b1;
                end else begin
                    nxt_qc = quiet_d[CNT_W-1:0];
                end
            end
            default: begin
                nxt_st = FS_NORM;
                nxt_pc = '0;
                nxt_qc = '0;
            end
        endcase
    end

endmodule

// File: rtl/oam_evt_pend.sv
module oam_evt_pend #(
    parameter int N_CONN = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_vld,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic              clr_vld,
    input  logic [IDX_W-1:0]  clr_idx,
    output logic [N_CONN-1:0] pend
);

    logic [N_CONN-1:0] pend_d, pend_q;

    always_comb begin
        for (int i = 0; i < N_CONN; i++) begin
            pend_d[i] = pend_q[i];
            if (clr_vld && clr_idx == IDX_W'(i)) pend_d[i] = 1'b0;
            if (set_vld && set_idx == IDX_W'(i)) pend_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    for (genvar i = 0; i < N_CONN; i++) begin : g_chk
        // R10
        set_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vld && set_idx == IDX_W'(i)) |=> pend_q[i]);
        // R10
        clr_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vld && clr_idx == IDX_W'(i) && !(set_vld && set_idx == IDX_W'(i)))
            |=> !pend_q[i]);
    end

endmodule

// File: rtl/oam_scan_ptr.sv
module oam_scan_ptr #(
    parameter int N_CONN = 16,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CONN - 1);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (step) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R9
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));
    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ptr_q));

endmodule

// File: rtl/oam_f5_supervisor.sv
module oam_f5_supervisor
    import oam_sup_pkg::*;
#(
    parameter int N_CONN      = 16,
    parameter int FAIL_TICKS  = 3,
    parameter int CLEAR_TICKS = 4,
    parameter int LOC_TICKS   = 5,
    parameter int IDX_W       = $clog2(N_CONN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic              ais_cell_vld,
    input  logic [IDX_W-1:0]  ais_cell_conn,
    input  logic              rdi_cell_vld,
    input  logic [IDX_W-1:0]  rdi_cell_conn,
    input  logic              cc_cell_vld,
    input  logic [IDX_W-1:0]  cc_cell_conn,
    input  logic              phy_err,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_conn,
    output logic              rd_vld,
    output logic [STAT_W-1:0] rd_data,
    output logic              fwd_ais_req,
    output logic [IDX_W-1:0]  fwd_ais_conn,
    output logic              bwd_rdi_req,
    output logic [IDX_W-1:0]  bwd_rdi_conn
);

    localparam int MAX_A = (FAIL_TICKS > CLEAR_TICKS) ? FAIL_TICKS : CLEAR_TICKS;
    localparam int MAX_T = (MAX_A > LOC_TICKS) ? MAX_A : LOC_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        fstate_e st;
        cnt_t    pc;
        cnt_t    qc;
    } fault_t;

    typedef struct packed {
        fault_t [N_FLT-1:0] flt;
        cnt_t               lw;
        logic [IND_W-1:0]   ind;
    } conn_t;

    typedef struct packed {
        conn_t [N_CONN-1:0] conn;
        logic               rd_vld;
        logic [STAT_W-1:0]  rd_data;
        logic               fwd_req;
        logic               bwd_req;
        logic [IDX_W-1:0]   req_conn;
    } sup_t;

    localparam cnt_t LOC_LIM = cnt_t'(LOC_TICKS);

    sup_t s_d, s_q;

    function automatic logic [STAT_W-1:0] status_of(conn_t c);
        logic [STAT_W-1:0] w;
        w = '0;
        for (int f = 0; f < N_FLT; f++) begin
            w[2*f]   = (c.flt[f].st == FS_DEF);
            w[2*f+1] = (c.flt[f].st == FS_FAIL);
        end
        w[IND_LSB +: IND_W] = c.ind;
        return w;
    endfunction

    // scan index
    logic [IDX_W-1:0] ptr;

    oam_scan_ptr #(.N_CONN(N_CONN), .IDX_W(IDX_W)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (scan_en),
        .ptr   (ptr)
    );

    // pending event flags, one bank per fault slot
    logic             evt_vld [N_FLT];
    logic [IDX_W-1:0] evt_idx [N_FLT];
    logic [N_CONN-1:0] pend_vec [N_FLT];

    assign evt_vld[F_AIS] = ais_cell_vld;
    assign evt_idx[F_AIS] = ais_cell_conn;
    assign evt_vld[F_RDI] = rdi_cell_vld;
    assign evt_idx[F_RDI] = rdi_cell_conn;
    assign evt_vld[F_LOC] = cc_cell_vld;
    assign evt_idx[F_LOC] = cc_cell_conn;

    for (genvar f = 0; f < N_FLT; f++) begin : g_pend
        oam_evt_pend #(.N_CONN(N_CONN), .IDX_W(IDX_W)) u_pend (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vld (evt_vld[f]),
            .set_idx (evt_idx[f]),
            .clr_vld (scan_en),
            .clr_idx (ptr),
            .pend    (pend_vec[f])
        );
    end

    // visited record, fault evidence and LOC window
    conn_t            cur_c;
    cnt_t             lw_n;
    logic [N_FLT-1:0] hit;

    always_comb begin
        cur_c = s_q.conn[ptr];
        if (pend_vec[F_LOC][ptr])   lw_n = '0;
        else if (cur_c.lw == LOC_LIM) lw_n = cur_c.lw;
        else                        lw_n = cur_c.lw + 1'b1;
        hit[F_AIS] = pend_vec[F_AIS][ptr];
        hit[F_RDI] = pend_vec[F_RDI][ptr];
        hit[F_LOC] = (lw_n == LOC_LIM);
    end

    // one state step per fault slot
    fstate_e          nxt_st [N_FLT];
    cnt_t             nxt_pc [N_FLT];
    cnt_t             nxt_qc [N_FLT];
    logic [N_FLT-1:0] flt_tf, flt_tn;

    for (genvar f = 0; f < N_FLT; f++) begin : g_flt
        oam_flt_step #(
            .FAIL_TICKS  (FAIL_TICKS),
            .CLEAR_TICKS (CLEAR_TICKS),
            .CNT_W       (CNT_W)
        ) u_step (
            .cur_st  (cur_c.flt[f].st),
            .cur_pc  (cur_c.flt[f].pc),
            .cur_qc  (cur_c.flt[f].qc),
            .hit     (hit[f]),
            .nxt_st  (nxt_st[f]),
            .nxt_pc  (nxt_pc[f]),
            .nxt_qc  (nxt_qc[f]),
            .to_fail (flt_tf[f]),
            .to_norm (flt_tn[f])
        );
    end

    // LOC transitions have no indication field
    logic unused_loc_ind;
    assign unused_loc_ind = flt_tf[F_LOC] | flt_tn[F_LOC];

    logic [IND_W-1:0] new_ind;
    assign new_ind = {flt_tn[F_RDI], flt_tf[F_RDI], flt_tn[F_AIS], flt_tf[F_AIS]};

    always_comb begin
        s_d = s_q;
        s_d.rd_vld  = rd_en;
        s_d.rd_data = rd_en ? status_of(s_q.conn[rd_conn]) : '0;
        s_d.fwd_req = 1'b0;
        s_d.bwd_req = 1'b0;
        if (rd_en) s_d.conn[rd_conn].ind = '0;
        if (scan_en) begin
            for (int f = 0; f < N_FLT; f++) begin
                s_d.conn[ptr].flt[f].st = nxt_st[f];
                s_d.conn[ptr].flt[f].pc = nxt_pc[f];
                s_d.conn[ptr].flt[f].qc = nxt_qc[f];
            end
            s_d.conn[ptr].lw  = lw_n;
            s_d.conn[ptr].ind = s_d.conn[ptr].ind | new_ind;
            s_d.fwd_req  = phy_err;
            s_d.bwd_req  = phy_err || (nxt_st[F_AIS] == FS_FAIL) || (nxt_st[F_LOC] == FS_FAIL);
            s_d.req_conn = ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_vld       = s_q.rd_vld;
    assign rd_data      = s_q.rd_data;
    assign fwd_ais_req  = s_q.fwd_req;
    assign fwd_ais_conn = s_q.req_conn;
    assign bwd_rdi_req  = s_q.bwd_req;
    assign bwd_rdi_conn = s_q.req_conn;

    // R7
    fwd_needs_visit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_ais_req |-> $past(scan_en && phy_err));
    // R7
    fwd_on_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && phy_err) |=> (fwd_ais_req && fwd_ais_conn == $past(ptr)));
    // R8
    bwd_on_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && phy_err) |=> (bwd_rdi_req && bwd_rdi_conn == $past(ptr)));
    // R8
    bwd_needs_visit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bwd_rdi_req |-> $past(scan_en));
    // R6
    rd_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_vld);
    // R4
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> (rd_data[7:6] == 2'b00 && rd_data[15:12] == 4'h0));

    for (genvar i = 0; i < N_CONN; i++) begin : g_conn_chk
        // R5
        ind_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_en && rd_conn == IDX_W'(i))
            |=> ((s_q.conn[i].ind & $past(s_q.conn[i].ind)) == $past(s_q.conn[i].ind)));
        // R6
        rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_conn == IDX_W'(i) && !(scan_en && ptr == IDX_W'(i)))
            |=> (s_q.conn[i].ind == '0));
        for (genvar f = 0; f < N_FLT; f++) begin : g_flt_chk
            // R2
            no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (s_q.conn[i].flt[f].st == FS_FAIL) |-> ($past(s_q.conn[i].flt[f].st) != FS_NORM));
        end
    end

endmodule

// File: tb/test_oam_f5_supervisor.sv
module test_oam_f5_supervisor;

    localparam int PN  = 16;
    localparam int PF  = 3;
    localparam int PC  = 4;
    localparam int PL  = 5;
    localparam int PIW = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic scan_en, ais_cell_vld, rdi_cell_vld, cc_cell_vld, phy_err, rd_en;
    logic [PIW-1:0] ais_cell_conn, rdi_cell_conn, cc_cell_conn, rd_conn;
    logic rd_vld, fwd_ais_req, bwd_rdi_req;
    logic [15:0] rd_data;
    logic [PIW-1:0] fwd_ais_conn, bwd_rdi_conn;

    always #5 clk = ~clk;

    oam_f5_supervisor #(
        .N_CONN(PN), .FAIL_TICKS(PF), .CLEAR_TICKS(PC), .LOC_TICKS(PL)
    ) i_oam_f5_supervisor (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
        .ais_cell_vld(ais_cell_vld), .ais_cell_conn(ais_cell_conn),
        .rdi_cell_vld(rdi_cell_vld), .rdi_cell_conn(rdi_cell_conn),
        .cc_cell_vld(cc_cell_vld), .cc_cell_conn(cc_cell_conn),
        .phy_err(phy_err), .rd_en(rd_en), .rd_conn(rd_conn),
        .rd_vld(rd_vld), .rd_data(rd_data),
        .fwd_ais_req(fwd_ais_req), .fwd_ais_conn(fwd_ais_conn),
        .bwd_rdi_req(bwd_rdi_req), .bwd_rdi_conn(bwd_rdi_conn)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // stimulus for the next step
    bit s_scan, s_ais, s_rdi, s_cc, s_phy, s_rd;
    int s_ais_c, s_rdi_c, s_cc_c, s_rd_c;

    // behavioural model: st 0 normal, 1 defect, 2 failure
    int m_st [3][PN];
    int m_pc [3][PN];
    int m_qc [3][PN];
    int m_pend [3][PN];
    int m_lw [PN];
    int m_ind [PN];
    int m_ptr;

    bit e_rd_vld, e_fwd, e_bwd;
    int e_rd_data, e_conn;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int status_of(int c);
        int w = 0;
        for (int f = 0; f < 3; f++) begin
            if (m_st[f][c] == 1) w |= 1 << (2*f);
            if (m_st[f][c] == 2) w |= 1 << (2*f+1);
        end
        return w | (m_ind[c] << 8);
    endfunction

    task automatic flt_upd(input int f, input int c, input bit hit, output bit tf, output bit tn);
        int q;
        tf = 0; tn = 0;
        if (m_st[f][c] == 0) begin
            if (hit) m_st[f][c] = 1;
            m_pc[f][c] = 0; m_qc[f][c] = 0;
        end else begin
            q = hit ? 0 : m_qc[f][c] + 1;
            if (q >= PC) begin
                if (m_st[f][c] == 2) tn = 1;
                m_st[f][c] = 0; m_pc[f][c] = 0; m_qc[f][c] = 0;
            end else if (m_st[f][c] == 1) begin
                if (m_pc[f][c] + 1 >= PF) begin
                    m_st[f][c] = 2; tf = 1; m_pc[f][c] = 0; m_qc[f][c] = 0;
                end else begin
                    m_pc[f][c]++; m_qc[f][c] = q;
                end
            end else begin
                m_qc[f][c] = q;
            end
        end
    endtask

    task automatic model_step();
        int v;
        bit tf, tn;
        bit h [3];
        e_rd_vld = s_rd;
        if (s_rd) begin
            e_rd_data = status_of(s_rd_c);
            m_ind[s_rd_c] = 0;
        end
        e_fwd = 0; e_bwd = 0;
        if (s_scan) begin
            v = m_ptr;
            h[0] = m_pend[0][v] != 0;
            h[1] = m_pend[1][v] != 0;
            if (m_pend[2][v] != 0) m_lw[v] = 0;
            else if (m_lw[v] < PL) m_lw[v]++;
            h[2] = (m_lw[v] == PL);
            for (int f = 0; f < 3; f++) begin
                flt_upd(f, v, h[f], tf, tn);
                if (f < 2) m_ind[v] |= (tf ? (1 << (2*f)) : 0) | (tn ? (2 << (2*f)) : 0);
            end
            for (int k = 0; k < 3; k++) m_pend[k][v] = 0;
            e_fwd = s_phy;
            e_bwd = s_phy || m_st[0][v] == 2 || m_st[2][v] == 2;
            e_conn = v;
            m_ptr = (m_ptr + 1) % PN;
        end
        if (s_ais) m_pend[0][s_ais_c] = 1;
        if (s_rdi) m_pend[1][s_rdi_c] = 1;
        if (s_cc)  m_pend[2][s_cc_c]  = 1;
    endtask

    task automatic compare();
        chk(rd_vld == e_rd_vld, "R6 rd_vld", rd_vld, e_rd_vld);
        if (e_rd_vld) begin
            chk(rd_data[3:0] == e_rd_data[3:0], "R2 AIS/RDI state bits", rd_data[3:0], e_rd_data[3:0]);
            chk(rd_data[5:4] == e_rd_data[5:4], "R3 LOC state bits", rd_data[5:4], e_rd_data[5:4]);
            chk(rd_data[11:8] == e_rd_data[11:8], "R5 indications", rd_data[11:8], e_rd_data[11:8]);
            chk(rd_data[7:6] == 0 && rd_data[15:12] == 0, "R4 zero bits", rd_data, e_rd_data);
        end
        chk(fwd_ais_req == e_fwd, "R7 forward request", fwd_ais_req, e_fwd);
        chk(bwd_rdi_req == e_bwd, "R8 backward request", bwd_rdi_req, e_bwd);
        if (e_fwd) chk(fwd_ais_conn == e_conn[PIW-1:0], "R9 forward index", fwd_ais_conn, e_conn);
        if (e_bwd) chk(bwd_rdi_conn == e_conn[PIW-1:0], "R9 backward index", bwd_rdi_conn, e_conn);
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        scan_en = s_scan; phy_err = s_phy; rd_en = s_rd;
        ais_cell_vld = s_ais; ais_cell_conn = s_ais_c[PIW-1:0];
        rdi_cell_vld = s_rdi; rdi_cell_conn = s_rdi_c[PIW-1:0];
        cc_cell_vld  = s_cc;  cc_cell_conn  = s_cc_c[PIW-1:0];
        rd_conn = s_rd_c[PIW-1:0];
        model_step();
    endtask

    task automatic quiet();
        s_scan = 0; s_ais = 0; s_rdi = 0; s_cc = 0; s_phy = 0; s_rd = 0;
        s_ais_c = 0; s_rdi_c = 0; s_cc_c = 0; s_rd_c = 0;
    endtask

    // read c; rd_data is valid when this returns
    task automatic read_conn(input int c, output logic [15:0] v);
        quiet(); s_rd = 1; s_rd_c = c; step();
        quiet(); step();
        v = rd_data;
    endtask

    // one full scan round; cells for every connection except 9 keep LOC away
    task automatic round(input int ais_c, input int rdi_c, input bit phy, input int rd_at, input int rd_c);
        for (int k = 0; k < PN; k++) begin
            quiet();
            s_scan = 1; s_phy = phy;
            s_cc = (k != 9); s_cc_c = k;
            if (k == 0 && ais_c >= 0) begin s_ais = 1; s_ais_c = ais_c; end
            if (k == 0 && rdi_c >= 0) begin s_rdi = 1; s_rdi_c = rdi_c; end
            if (k == rd_at) begin s_rd = 1; s_rd_c = rd_c; end
            step();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        for (int f = 0; f < 3; f++)
            for (int c = 0; c < PN; c++) begin
                m_st[f][c] = 0; m_pc[f][c] = 0; m_qc[f][c] = 0; m_pend[f][c] = 0;
            end
        for (int c = 0; c < PN; c++) begin m_lw[c] = 0; m_ind[c] = 0; end
        m_ptr = 0; e_rd_vld = 0; e_fwd = 0; e_bwd = 0; e_rd_data = 0; e_conn = 0;
        quiet();
        scan_en = 0; phy_err = 0; rd_en = 0; ais_cell_vld = 0; rdi_cell_vld = 0; cc_cell_vld = 0;
        ais_cell_conn = 0; rdi_cell_conn = 0; cc_cell_conn = 0; rd_conn = 0;
        rst_n = 0;
        repeat (4) @(negedge clk);
        // R1 outputs idle in reset
        chk(rd_vld == 0 && fwd_ais_req == 0 && bwd_rdi_req == 0, "R1 reset outputs",
            {rd_vld, fwd_ais_req, bwd_rdi_req}, 0);
        rst_n = 1;

        // R1 every status word is zero
        for (int c = 0; c < PN; c++) begin
            read_conn(c, v);
            chk(v == 16'h0000, "R1 reset status", v, 0);
        end

        // R10 cell arriving while its connection is visited waits a round
        round(0, -1, 0, -1, 0);
        read_conn(0, v);
        chk(v[1:0] == 2'b00, "R10 same-cycle event deferred", v[1:0], 0);
        round(-1, -1, 0, -1, 0);
        read_conn(0, v);
        chk(v[1:0] == 2'b01, "R10 deferred event consumed", v[1:0], 1);

        // R2 AIS defect then failure on conn 1, RDI on conn 2
        round(1, 2, 0, -1, 0);
        read_conn(1, v);
        chk(v[1:0] == 2'b01, "R2 AIS defect on first cell", v[1:0], 1);
        for (int r = 0; r < 3; r++) round(1, 2, 0, -1, 0);
        read_conn(1, v);
        chk(v[1:0] == 2'b10 && v[8] == 1'b1, "R2 R5 AIS failure and indication", v, 16'h0102);
        read_conn(1, v);
        chk(v[8] == 1'b0 && v[1:0] == 2'b10, "R6 indication cleared by read", v, 16'h0002);
        read_conn(2, v);
        chk(v[3:2] == 2'b10 && v[10] == 1'b1, "R2 R5 RDI failure and indication", v, 16'h0408);
        for (int r = 0; r < 4; r++) round(-1, -1, 0, -1, 0);
        read_conn(1, v);
        chk(v[1:0] == 2'b00 && v[9] == 1'b1, "R2 R5 AIS failure-to-normal", v, 16'h0200);

        // R3 conn 9 never sees a continuity cell
        read_conn(9, v);
        chk(v[5:4] == 2'b10, "R3 LOC failure", v[5:4], 2);

        // R6 read in the same cycle as the defect-to-failure step of conn 3
        for (int r = 0; r < 3; r++) round(3, -1, 0, -1, 0);
        round(3, -1, 0, 3, 3);
        read_conn(3, v);
        chk(v[8] == 1'b1 && v[1:0] == 2'b10, "R6 same-cycle transition survives read", v, 16'h0102);

        // R7 R8 line error drives both requests
        quiet(); s_scan = 1; s_phy = 1; step();
        quiet(); step();
        chk(fwd_ais_req == 1'b1 && bwd_rdi_req == 1'b1, "R7 R8 requests on line error",
            {fwd_ais_req, bwd_rdi_req}, 3);
        round(-1, -1, 1, -1, 0);

        // mixed traffic
        for (int i = 0; i < 6000; i++) begin
            quiet();
            s_scan = ($urandom % 4) != 0;
            if (((i / 1000) % 2) == 0) begin
                s_ais = ($urandom % 6) == 0; s_ais_c = $urandom % 4;
            end
            s_rdi = ($urandom % 7) == 0; s_rdi_c = 4 + ($urandom % 4);
            s_cc  = ($urandom % 2) == 0; s_cc_c  = $urandom % 12;
            s_phy = ((i / 700) % 4) == 3;
            s_rd  = ($urandom % 5) == 0; s_rd_c = $urandom % PN;
            step();
        end
        quiet(); step(); step();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule